// File: doc/BRIEF.md
# NAND Flash Target Command Responder

This block is a synthesizable stand-in for the control side of a byte-wide asynchronous NAND flash part. A flash controller under test drives it through the usual chip-select, latch-select, write-strobe, read-strobe and write-protect pins. A single system clock samples every pin through a two-stage synchronizer. Each rising write strobe is then classed as a command, address or data cycle. Each falling read strobe returns the next byte from the selected output source.

The block holds one small page buffer. Program data is loaded into it at a column picked by the address cycles, and erase fills it with FFh. Reads stream it out from a column. The block also answers the identifier query and the status query. After read, program, erase and reset commands it holds ready/busy low for a clock count set by a parameter. The cell array, multi-plane operation and cache operation are not modelled.

The control state machine has four states. ST_IDLE waits for a command. ST_ADDR counts address cycles until the amount the command needs has arrived. ST_CONF waits for the confirm command of a read, a column change or an erase. ST_DIN accepts program data. The transitions are:
- Any command that takes an address moves the machine into ST_ADDR: 00h, 05h, 60h, 80h, 90h and 78h, plus 85h when the machine is in ST_DIN.
- ST_ADDR moves to ST_CONF after the last address of 00h, 05h or 60h.
- ST_ADDR moves to ST_DIN after the last address of 80h or 85h.
- ST_ADDR returns to ST_IDLE after the address of 90h or 78h.
- ST_CONF returns to ST_IDLE on 30h, E0h or D0h.
- ST_DIN returns to ST_IDLE on 10h.
- FFh sends the machine to ST_IDLE from any state.

Top module: `nand_target`

## Requirements
- R1: Every cycle type needs chip select low on the write-strobe rising edge. CLE high with ALE low gives a command. ALE high with CLE low gives an address. Both low gives a data byte. Any other combination, or chip select high, has no effect.
- R2: Each read-strobe falling edge with chip select low puts the page-buffer byte at the current column on io_out, then adds one to the column, wrapping at PAGE_BYTES. Program data bytes are written starting at the column the address gave, one column further per byte.
- R3: While ready/busy is low, only FFh, 70h and 78h are acted on. Every other command, and every address or data cycle that belongs to one, is ignored.
- R4: io_oe is high only while chip select and read strobe are both low and an output source (page, identifier or status) is selected. After reset no source is selected.
- R5: Command 90h followed by address byte 00h selects the identifier. Successive read pulses then return ADh, D7h, 94h, 9Ah, 74h, 42h. Any other address byte selects no source.
- R6: The status byte has these bits. Bit 7 is the sampled write-protect pin, so it is 1 when not protected. Bit 6 is 1 when ready. Bit 5 is 1 when no array operation runs. Bit 0 is 1 when the last program or erase was refused. Bits 4 to 1 are 0. It is selected by 70h, or by 78h plus three address cycles, and is sampled at each read pulse.
- R7: With write-protect low at the confirm command (10h or D0h), program and erase do not start. Ready/busy stays high and the page buffer keeps its contents. The pin is sampled every clock, not latched by the write strobe.
- R8: 00h and 80h take five address cycles, 60h and 78h three, 05h and 85h two, and 90h one. The first cycle is the column low byte and the second the column high byte. Further address cycles are ignored.
- R9: A started read (30h), program (10h) or erase (D0h) holds ready/busy low for exactly READ_CLKS, PROG_CLKS or ERASE_CLKS clocks.
- R10: FFh, whether ready or busy, ends any operation, selects no output and holds ready/busy low for RST_CLKS clocks.
- R11: A started erase fills every page-buffer byte with FFh.
- R12: After rst_n, ready/busy is high, no output source is selected and the page buffer holds FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe, latched on its rising edge |
| re_n | input | 1 | Read strobe, advances output on its falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus from the controller |
| io_out | output | 8 | Byte bus to the controller |
| io_oe | output | 1 | Drive enable for io_out |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
Some rules are checked on every cycle by the assertions. The output enable is never active without chip select and read strobe. The busy counter falls by exactly one per clock unless it is reloaded. A reset command always drives busy. A refused program or erase never raises busy. A non-permitted command during busy leaves the state and the output source untouched. A page read pulse always advances the column by one. Other behaviour can only be shown by the bench's scenarios, because each needs a whole command sequence: the identifier byte order, the status encoding in each condition, the data seen after program, column change, extra address cycles and erase, and the exact busy length for each command.

// File: rtl/nand_target_pkg.sv
`timescale 1ns/1ps
package nand_target_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CONF, ST_DIN} ctl_st_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_COLSEL, OP_PROG, OP_COLIN, OP_ERASE, OP_IDQ, OP_PSTAT
    } pend_op_e;

    typedef enum logic [1:0] {SRC_OFF, SRC_PAGE, SRC_IDENT, SRC_STAT} out_src_e;

    localparam logic [7:0] C_RD_SETUP  = 8'h00;
    localparam logic [7:0] C_RD_GO     = 8'h30;
    localparam logic [7:0] C_COL_SETUP = 8'h05;
    localparam logic [7:0] C_COL_GO    = 8'hE0;
    localparam logic [7:0] C_PG_SETUP  = 8'h80;
    localparam logic [7:0] C_PG_COL    = 8'h85;
    localparam logic [7:0] C_PG_GO     = 8'h10;
    localparam logic [7:0] C_ER_SETUP  = 8'h60;
    localparam logic [7:0] C_ER_GO     = 8'hD0;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_STAT      = 8'h70;
    localparam logic [7:0] C_PSTAT     = 8'h78;
    localparam logic [7:0] C_RESET     = 8'hFF;

    function automatic logic [7:0] ident_byte(input logic [2:0] k);
        case (k)
            3'd0:    return 8'hAD;
            3'd1:    return 8'hD7;
            3'd2:    return 8'h94;
            3'd3:    return 8'h9A;
            3'd4:    return 8'h74;
            default: return 8'h42;
        endcase
    endfunction

endpackage

// File: rtl/nand_target_sync.sv
`timescale 1ns/1ps
module nand_target_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            d_out  <= RST_VAL;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/nand_target_pbuf.sv
`timescale 1ns/1ps
module nand_target_pbuf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          fill,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (fill) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nand_target.sv
`timescale 1ns/1ps
module nand_target
    import nand_target_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int READ_CLKS  = 30,
    parameter int PROG_CLKS  = 200,
    parameter int ERASE_CLKS = 300,
    parameter int RST_CLKS   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_n
);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int MAX_A  = (READ_CLKS > PROG_CLKS) ? READ_CLKS : PROG_CLKS;
    localparam int MAX_B  = (ERASE_CLKS > RST_CLKS) ? ERASE_CLKS : RST_CLKS;
    localparam int BMAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(BMAX + 1);
    localparam int SYNC_W = 14;

    // synchronised pins
    logic [SYNC_W-1:0] pins_s;
    logic       ce_s, cle_s, ale_s, we_s, re_s, wp_s;
    logic [7:0] io_s;
    logic       we_d, re_d;

    nand_target_sync #(.W(SYNC_W), .RST_VAL(14'b0000_0000_0110_01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({io_in, wp_n, re_n, we_n, ale, cle, ce_n}),
        .d_out (pins_s)
    );
    assign {io_s, wp_s, re_s, we_s, ale_s, cle_s, ce_s} = pins_s;

    logic we_rise, re_fall, cmd_cyc, adr_cyc, dat_cyc, busy, cmd_ok;
    assign we_rise = we_s & ~we_d;
    assign re_fall = ~re_s & re_d;
    assign cmd_cyc = we_rise & ~ce_s &  cle_s & ~ale_s;
    assign adr_cyc = we_rise & ~ce_s & ~cle_s &  ale_s;
    assign dat_cyc = we_rise & ~ce_s & ~cle_s & ~ale_s;

    // control state
    ctl_st_e    state, state_n;
    pend_op_e   op, op_n;
    logic [2:0] need, need_n, acnt;
    logic [CNT_W-1:0] bcnt;
    out_src_e   src;
    logic [COL_W-1:0] ptr, acol, col_nx;
    logic [2:0] idx;
    logic       fail;
    logic [7:0] out_q, rd_byte, stat_byte;

    assign busy   = (bcnt != '0);
    assign cmd_ok = ~busy | (io_s == C_RESET) | (io_s == C_STAT) | (io_s == C_PSTAT);
    assign col_nx = (acnt == 3'd1) ? COL_W'({io_s, 8'(acol)}) : acol;

    logic go_addr, go_rd, go_col, go_prog, go_erase, go_reset, go_id, go_stat, go_din;
    logic busy_ld, pe_req;

    always_comb begin
        state_n = state; op_n = op; need_n = need;
        go_addr = 1'b0; go_rd = 1'b0; go_col = 1'b0; go_prog = 1'b0; go_erase = 1'b0;
        go_reset = 1'b0; go_id = 1'b0; go_stat = 1'b0; go_din = 1'b0;
        if (cmd_ok && cmd_cyc) begin
            unique case (io_s)
                C_RESET:     begin state_n = ST_IDLE; op_n = OP_NONE; go_reset = 1'b1; end
                C_STAT:      go_stat = 1'b1;
                C_PSTAT:     begin state_n = ST_ADDR; op_n = OP_PSTAT; need_n = 3'd3; go_addr = 1'b1; end
                C_RD_SETUP:  begin state_n = ST_ADDR; op_n = OP_READ;  need_n = 3'd5; go_addr = 1'b1; end
                C_COL_SETUP: begin state_n = ST_ADDR; op_n = OP_COLSEL; need_n = 3'd2; go_addr = 1'b1; end
                C_PG_SETUP:  begin state_n = ST_ADDR; op_n = OP_PROG;  need_n = 3'd5; go_addr = 1'b1; end
                C_ER_SETUP:  begin state_n = ST_ADDR; op_n = OP_ERASE; need_n = 3'd3; go_addr = 1'b1; end
                C_IDENT:     begin state_n = ST_ADDR; op_n = OP_IDQ;   need_n = 3'd1; go_addr = 1'b1; end
                C_PG_COL:    if (state == ST_DIN) begin
                                 state_n = ST_ADDR; op_n = OP_COLIN; need_n = 3'd2; go_addr = 1'b1;
                             end
                C_RD_GO:     if (state == ST_CONF && op == OP_READ) begin
                                 state_n = ST_IDLE; op_n = OP_NONE; go_rd = 1'b1;
                             end
                C_COL_GO:    if (state == ST_CONF && op == OP_COLSEL) begin
                                 state_n = ST_IDLE; op_n = OP_NONE; go_col = 1'b1;
                             end
                C_ER_GO:     if (state == ST_CONF && op == OP_ERASE) begin
                                 state_n = ST_IDLE; op_n = OP_NONE; go_erase = 1'b1;
                             end
                C_PG_GO:     if (state == ST_DIN) begin
                                 state_n = ST_IDLE; op_n = OP_NONE; go_prog = 1'b1;
                             end
                default: ;
            endcase
        end else if (adr_cyc && state == ST_ADDR && (acnt + 3'd1) == need) begin
            unique case (op)
                OP_READ, OP_COLSEL, OP_ERASE: state_n = ST_CONF;
                OP_PROG, OP_COLIN:            begin state_n = ST_DIN; go_din = 1'b1; end
                OP_IDQ:                       begin state_n = ST_IDLE; op_n = OP_NONE; go_id = 1'b1; end
                default:                      begin state_n = ST_IDLE; op_n = OP_NONE; go_stat = 1'b1; end
            endcase
        end
    end

    assign pe_req  = go_prog | go_erase;
    assign busy_ld = go_reset | go_rd | (pe_req & wp_s);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op    <= OP_NONE;
            need  <= 3'd0;
        end else begin
            state <= state_n;
            op    <= op_n;
            need  <= need_n;
        end
    end

    logic wr_en;
    assign wr_en = dat_cyc & (state == ST_DIN) & ~busy;

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_d <= 1'b1; re_d <= 1'b1;
            acnt <= '0; acol <= '0; ptr <= '0; idx <= '0;
            bcnt <= '0; src <= SRC_OFF; fail <= 1'b0; out_q <= 8'h00;
        end else begin
            we_d <= we_s;
            re_d <= re_s;
            if (go_addr) acnt <= '0;
            else if (adr_cyc && state == ST_ADDR) begin
                acnt <= acnt + 3'd1;
                if (acnt == 3'd0) acol <= COL_W'(io_s);
                if (acnt == 3'd1) acol <= COL_W'({io_s, 8'(acol)});
            end
            if (busy_ld) begin
                if (go_reset)    bcnt <= CNT_W'(RST_CLKS);
                else if (go_rd)  bcnt <= CNT_W'(READ_CLKS);
                else if (go_prog) bcnt <= CNT_W'(PROG_CLKS);
                else             bcnt <= CNT_W'(ERASE_CLKS);
            end else if (busy) bcnt <= bcnt - 1'b1;
            if (go_reset) fail <= 1'b0;
            else if (pe_req) fail <= ~wp_s;
            if (go_reset || (go_addr && op_n != OP_PSTAT) || pe_req) src <= SRC_OFF;
            else if (go_stat) src <= SRC_STAT;
            else if (go_id) begin
                src <= (io_s == 8'h00) ? SRC_IDENT : SRC_OFF;
                idx <= '0;
            end else if (go_rd || go_col) begin
                src <= SRC_PAGE;
                ptr <= acol;
            end
            if (go_din) ptr <= col_nx;
            else if (wr_en) ptr <= ptr + 1'b1;
            else if (re_fall && !ce_s) begin
                unique case (src)
                    SRC_PAGE:  begin out_q <= rd_byte; ptr <= ptr + 1'b1; end
                    SRC_IDENT: begin
                        out_q <= ident_byte(idx);
                        if (idx != 3'd5) idx <= idx + 3'd1;
                    end
                    SRC_STAT:  out_q <= stat_byte;
                    default:   ;
                endcase
            end
        end
    end

    assign stat_byte = {wp_s, ~busy, ~busy, 4'b0000, fail};

    nand_target_pbuf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (io_s),
        .fill    (go_erase & wp_s),
        .rd_addr (ptr),
        .rd_data (rd_byte)
    );

    assign io_out = out_q;
    assign io_oe  = ~ce_n & ~re_n & (src != SRC_OFF);
    assign rb_n   = ~busy;
endmodule

// File: rtl/nand_target_chk.sv
`timescale 1ns/1ps
module nand_target_chk #(
    parameter int COL_W = 4,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             re_n,
    input logic             io_oe,
    input logic             rb_n,
    input logic             wp_s,
    input logic             ce_s,
    input logic             busy_ld,
    input logic             pe_req,
    input logic [CNT_W-1:0] bcnt,
    input logic             cmd_cyc,
    input logic [7:0]       cmd_byte,
    input logic [1:0]       st,
    input logic [1:0]       omode,
    input logic             re_fall,
    input logic [COL_W-1:0] ptr
);
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> (!ce_n && !re_n)); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && !ce_s && omode == 2'd1) |=> (ptr == COL_W'($past(ptr) + 1'b1))); // R2

    AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cyc && !rb_n && cmd_byte != 8'hFF && cmd_byte != 8'h70 && cmd_byte != 8'h78)
        |=> ($stable(st) && $stable(omode))); // R3

    AST_WP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_req && !wp_s && rb_n) |=> rb_n); // R7

    AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bcnt != '0 && !busy_ld) |=> (bcnt == CNT_W'($past(bcnt) - 1'b1))); // R9

    AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cyc && cmd_byte == 8'hFF) |=> !rb_n); // R10
endmodule

bind nand_target nand_target_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .re_n     (re_n),
    .io_oe    (io_oe),
    .rb_n     (rb_n),
    .wp_s     (wp_s),
    .ce_s     (ce_s),
    .busy_ld  (busy_ld),
    .pe_req   (pe_req),
    .bcnt     (bcnt),
    .cmd_cyc  (cmd_cyc),
    .cmd_byte (io_s),
    .st       (state),
    .omode    (src),
    .re_fall  (re_fall),
    .ptr      (ptr)
);

// File: tb/nand_target_tb.sv
`timescale 1ns/1ps
module nand_target_tb_top;
    localparam int PB = 16, TR = 30, TP = 200, TE = 300, TZ = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb_n;

    int nchk = 0, nerr = 0, lowcnt = 0;
    logic [7:0] mdl [PB];

    always #2 clk = ~clk;

    nand_target #(.PAGE_BYTES(PB), .READ_CLKS(TR), .PROG_CLKS(TP),
                  .ERASE_CLKS(TE), .RST_CLKS(TZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n)
    );

    always @(negedge clk) if (rst_n && !rb_n) lowcnt++;

    function automatic logic [7:0] exp_id(input int k);
        case (k)
            0: return 8'hAD; 1: return 8'hD7; 2: return 8'h94;
            3: return 8'h9A; 4: return 8'h74; default: return 8'h42;
        endcase
    endfunction

    function automatic logic [7:0] exp_stat(input logic wp, input logic rdy, input logic fl);
        return {wp, rdy, rdy, 4'b0000, fl};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk); cle = c; ale = a; io_in = b;
        repeat (2) @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b1;
        repeat (3) @(negedge clk); cle = 1'b0; ale = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b); wcyc(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); wcyc(1'b0, 1'b1, b); endtask
    task automatic din(input logic [7:0] b); wcyc(1'b0, 1'b0, b); endtask

    task automatic rd(output logic [7:0] v, output logic oe);
        @(negedge clk); re_n = 1'b0;
        repeat (5) @(negedge clk); v = io_out; oe = io_oe;
        re_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_rdy();
        int g = 0;
        while (!rb_n && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic addr5(input logic [7:0] col);
        adr(col); adr(8'h00); adr(8'h00); adr(8'h00); adr(8'h00);
    endtask

    task automatic col_sel(input logic [7:0] col);
        cmd(8'h05); adr(col); adr(8'h00); cmd(8'hE0);
    endtask

    initial begin
        #(4ns * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int base;
        void'($urandom(32'd24681));
        for (int i = 0; i < PB; i++) mdl[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12 reset state
        check(rb_n === 1'b1, "R12 ready after reset", rb_n, 1);
        check(io_oe === 1'b0, "R12 no output after reset", io_oe, 0);
        ce_n = 1'b0;
        rd(v, oe);
        check(oe === 1'b0, "R4 no source selected", oe, 0);
        col_sel(8'd5);
        rd(v, oe);
        check(v === 8'hFF, "R12 buffer erased at reset", v, 8'hFF);

        // R5 identifier
        cmd(8'h90); adr(8'h00);
        for (int k = 0; k < 6; k++) begin
            rd(v, oe);
            check(v === exp_id(k) && oe === 1'b1, "R5 ident byte", v, exp_id(k));
        end
        cmd(8'h90); adr(8'h20);
        rd(v, oe);
        check(oe === 1'b0, "R5 ident needs address 00h", oe, 0);

        // R6 status while ready
        cmd(8'h70);
        rd(v, oe);
        check(v === exp_stat(1, 1, 0), "R6 status ready", v, exp_stat(1, 1, 0));

        // R4 output enable gating
        @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
        repeat (2) @(negedge clk);
        check(io_oe === 1'b0, "R4 chip select high", io_oe, 0);
        ce_n = 1'b0;
        @(negedge clk);
        check(io_oe === 1'b1, "R4 enabled with ce and re low", io_oe, 1);
        re_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 invalid cycle types leave status selected
        wcyc(1'b1, 1'b1, 8'h90); adr(8'h00);
        @(negedge clk); ce_n = 1'b1;
        cmd(8'h05);
        @(negedge clk); ce_n = 1'b0;
        rd(v, oe);
        check(v === exp_stat(1, 1, 0), "R1 CLE+ALE and CE-high cycles ignored", v, exp_stat(1, 1, 0));

        // R1 R2 R9 random program then random column read-back
        for (int it = 0; it < 8; it++) begin
            int c, n, r;
            c = int'($urandom % PB);
            n = 1 + int'($urandom % 6);
            base = lowcnt;
            cmd(8'h80); addr5(8'(c));
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                din(b);
                mdl[(c + i) % PB] = b;
            end
            cmd(8'h10);
            wait_rdy();
            check(lowcnt - base == TP, "R9 program busy length", lowcnt - base, TP);
            r = int'($urandom % PB);
            col_sel(8'(r));
            for (int i = 0; i < 4; i++) begin
                rd(v, oe);
                check(v === mdl[(r + i) % PB], "R2 column stream after R1 data load",
                      v, mdl[(r + i) % PB]);
            end
        end

        // R8 extra address cycle ignored
        cmd(8'h05); adr(8'd2); adr(8'h00); adr(8'd9); cmd(8'hE0);
        rd(v, oe);
        check(v === mdl[2], "R8 third column address ignored", v, mdl[2]);

        // R3 busy filtering
        cmd(8'h80); addr5(8'd1); din(8'h3C); mdl[1] = 8'h3C; cmd(8'h10);
        cmd(8'h70);
        cmd(8'h05); adr(8'h00); adr(8'h00); cmd(8'hE0);
        rd(v, oe);
        check(v === exp_stat(1, 0, 0), "R6 status while busy", v, exp_stat(1, 0, 0));
        wait_rdy();
        rd(v, oe);
        check(v === exp_stat(1, 1, 0), "R3 column change ignored during busy", v, exp_stat(1, 1, 0));

        // R7 write protect
        @(negedge clk); wp_n = 1'b0;
        base = lowcnt;
        cmd(8'h80); addr5(8'd0); din(8'h5A); mdl[0] = 8'h5A; cmd(8'h10);
        repeat (20) @(negedge clk);
        check(lowcnt - base == 0, "R7 program refused", lowcnt - base, 0);
        cmd(8'h70); rd(v, oe);
        check(v === exp_stat(0, 1, 1), "R6 R7 status protected and failed", v, exp_stat(0, 1, 1));
        base = lowcnt;
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
        repeat (20) @(negedge clk);
        check(lowcnt - base == 0, "R7 erase refused", lowcnt - base, 0);
        col_sel(8'd0); rd(v, oe);
        check(v === 8'h5A, "R7 buffer kept", v, 8'h5A);

        // R11 R9 erase with protection off
        @(negedge clk); wp_n = 1'b1;
        base = lowcnt;
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
        wait_rdy();
        check(lowcnt - base == TE, "R9 erase busy length", lowcnt - base, TE);
        for (int i = 0; i < PB; i++) mdl[i] = 8'hFF;
        cmd(8'h70); rd(v, oe);
        check(v === exp_stat(1, 1, 0), "R6 status after good erase", v, exp_stat(1, 1, 0));
        col_sel(8'd7);
        for (int i = 0; i < 3; i++) begin
            rd(v, oe);
            check(v === 8'hFF, "R11 erased byte", v, 8'hFF);
        end

        // R9 page read
        cmd(8'h80); addr5(8'd3); din(8'hA1); din(8'hB2); cmd(8'h10); wait_rdy();
        base = lowcnt;
        cmd(8'h00); addr5(8'd3); cmd(8'h30);
        wait_rdy();
        check(lowcnt - base == TR, "R9 read busy length", lowcnt - base, TR);
        rd(v, oe);
        check(v === 8'hA1, "R2 read stream first", v, 8'hA1);
        rd(v, oe);
        check(v === 8'hB2, "R2 read stream second", v, 8'hB2);

        // R10 reset while ready and while busy
        base = lowcnt;
        cmd(8'hFF);
        wait_rdy();
        check(lowcnt - base == TZ, "R10 reset busy length", lowcnt - base, TZ);
        rd(v, oe);
        check(oe === 1'b0, "R10 reset deselects output", oe, 0);
        base = lowcnt;
        cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
        cmd(8'hFF);
        wait_rdy();
        check(lowcnt - base < TE / 2, "R10 reset aborts erase", lowcnt - base, TE / 2);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule